// File: doc/BRIEF.md
# SMBus Target Transaction Decoder

This block sits on top of a byte-level I2C target engine and turns the engine's event stream into SMBus transactions for a register backend. The engine reports start-for-write, start-for-read, stop and NACK events as single-cycle pulses. It also delivers each written byte with a valid pulse and raises a read request whenever it needs a byte to shift out. The decoder tracks where the current transaction stands. It counts the bytes written since the start and works out the transaction type from that count when a stop or a repeated start arrives. The possible types are quick command, send byte, receive byte, write with a command code, and command followed by a read.

The backend sees single-cycle strobes. A quick command carries a direction bit. A send-byte strobe carries its data byte. A write strobe carries the command, an offset and a data byte. For reads there is a receive-byte request and a read request that carries the command and an offset. The backend answers both read requests combinationally on `be_rdata`. An illegal order of events parks the decoder in a confused state until the next stop. Overflow of the write window and a stop in the middle of a read are reported as flags.

Top module: `smbus_target_decoder`

## Requirements
- R1: After reset the decoder is idle: all strobes, `rd_vld`, `rd_byte`, `confused`, `overflow` and `stop_err` are 0.
- R2: A start-for-write followed by a stop with no bytes written pulses `quick_stb` with `quick_rd`=0 in the cycle after the stop.
- R3: A start-for-read from idle followed by a stop with no read pulses `quick_stb` with `quick_rd`=1 in the cycle after the stop.
- R4: A start-for-write, exactly one byte, then a stop pulses `send_stb` with `send_data` equal to that byte in the cycle after the stop. No `write_stb` is produced for that byte.
- R5: In a write, the first byte becomes the command. Each later byte pulses `write_stb` in the next cycle with `write_cmd` set to the command, `write_off` counting from 0, and `write_data` set to the byte.
- R6: After a start-for-read from idle, the first read request raises `recv_req` in the same cycle, and `rd_byte` holds `be_rdata` in the next cycle with `rd_vld`=1. Any further read in that transaction returns 0 and sets `confused`.
- R7: A start-for-read while at least one byte has been written enters read mode. Each read raises `read_req` in the same cycle with `read_cmd` set to the command and `read_off` starting at 0 and then incrementing. The following cycle returns `be_rdata` on `rd_byte`.
- R8: Any start while not idle sets `confused`. This includes a start-for-read after a start-for-write with zero bytes written. The one exception is the legal repeated start of R7.
- R9: A NACK during read mode ends the read without error, and a NACK after that is ignored. A NACK in any other state (for example idle) sets `confused`.
- R10: A written byte outside write mode is dropped. It does not produce a write strobe and does not change the transaction type decided at the stop.
- R11: `confused` stays set until a stop. The stop returns the decoder to idle and produces no strobe.
- R12: A write keeps at most 34 bytes (command plus offsets 0 to 32). Later bytes are dropped, produce no strobe, and set `overflow` until the next stop.
- R13: A stop during read mode pulses `stop_err` for one cycle and still returns the decoder to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_wr | input | 1 | Start (or repeated start) for write event |
| start_rd | input | 1 | Start (or repeated start) for read event |
| stop | input | 1 | Stop event |
| nack | input | 1 | Controller NACK event |
| wr_vld | input | 1 | Written byte valid |
| wr_byte | input | 8 | Written byte |
| rd_req | input | 1 | Engine requests a byte to transmit |
| rd_byte | output | 8 | Byte returned to the engine |
| rd_vld | output | 1 | `rd_byte` valid pulse |
| quick_stb | output | 1 | Quick command strobe |
| quick_rd | output | 1 | Quick command direction, 1 = read |
| send_stb | output | 1 | Send-byte strobe |
| send_data | output | 8 | Send-byte data |
| write_stb | output | 1 | Write data strobe |
| write_cmd | output | 8 | Write command code |
| write_off | output | 6 | Write data offset |
| write_data | output | 8 | Write data byte |
| recv_req | output | 1 | Receive-byte request to backend |
| read_req | output | 1 | Read-data request to backend |
| read_cmd | output | 8 | Read command code |
| read_off | output | 6 | Read offset |
| be_rdata | input | 8 | Backend read data for the current request |
| confused | output | 1 | Protocol error, held until stop |
| overflow | output | 1 | Write window exceeded, held until stop |
| stop_err | output | 1 | Stop arrived during read mode |

## Verification
The backend request outputs `recv_req` and `read_req` are combinational, so they are checked in the same cycle as `rd_req`, one nanosecond after the request is driven. Every other result comes from a register and is due one clock edge after its event. That covers all strobes, `rd_byte`/`rd_vld`, `stop_err` and the flags. The bench drives each event on a falling edge and removes it on the next falling edge, then samples the registered results at that second falling edge. Each result is therefore read in the single cycle it is valid, away from the rising edge that produced it.

// File: rtl/smbus_target_decoder.sv
module smbus_target_decoder #(
  parameter int MAX_BYTES = 34,
  parameter int CW = $clog2(MAX_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_wr,
  input  logic          start_rd,
  input  logic          stop,
  input  logic          nack,
  input  logic          wr_vld,
  input  logic [7:0]    wr_byte,
  input  logic          rd_req,
  output logic [7:0]    rd_byte,
  output logic          rd_vld,
  output logic          quick_stb,
  output logic          quick_rd,
  output logic          send_stb,
  output logic [7:0]    send_data,
  output logic          write_stb,
  output logic [7:0]    write_cmd,
  output logic [CW-1:0] write_off,
  output logic [7:0]    write_data,
  output logic          recv_req,
  output logic          read_req,
  output logic [7:0]    read_cmd,
  output logic [CW-1:0] read_off,
  input  logic [7:0]    be_rdata,
  output logic          confused,
  output logic          overflow,
  output logic          stop_err
);

  typedef enum logic [2:0] {S_IDLE, S_WRITE, S_RECV, S_READ, S_DONE, S_CONF} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic [7:0]   cmd;

  wire any_start = start_wr | start_rd;
  wire rd_go     = rd_req & ~(stop | any_start | nack);
  wire wr_go     = wr_vld & ~(stop | any_start | nack | rd_req) & (st == S_WRITE);

  assign recv_req = rd_go & (st == S_RECV);
  assign read_req = rd_go & (st == S_READ);
  assign read_cmd = cmd;
  assign read_off = cnt;
  assign write_cmd = cmd;
  assign confused = (st == S_CONF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      cmd <= '0;
      rd_byte <= '0;
      rd_vld <= 1'b0;
      quick_stb <= 1'b0;
      quick_rd <= 1'b0;
      send_stb <= 1'b0;
      send_data <= '0;
      write_stb <= 1'b0;
      write_off <= '0;
      write_data <= '0;
      overflow <= 1'b0;
      stop_err <= 1'b0;
    end else begin
      rd_vld <= 1'b0;
      quick_stb <= 1'b0;
      send_stb <= 1'b0;
      write_stb <= 1'b0;
      stop_err <= 1'b0;
      if (stop) begin
        case (st)
          S_WRITE:
            if (cnt == '0) begin
              quick_stb <= 1'b1;
              quick_rd <= 1'b0;
            end else if (cnt == CW'(1)) begin
              send_stb <= 1'b1;
              send_data <= cmd;
            end
          S_RECV: begin
            quick_stb <= 1'b1;
            quick_rd <= 1'b1;
          end
          S_READ: stop_err <= 1'b1;
          default: ;
        endcase
        st <= S_IDLE;
        cnt <= '0;
        overflow <= 1'b0;
      end else if (any_start) begin
        if (st == S_IDLE)
          st <= start_wr ? S_WRITE : S_RECV;
        else if (!start_wr && st == S_WRITE && cnt != '0) begin
          st <= S_READ;
          cnt <= '0;
        end else
          st <= S_CONF;
      end else if (nack) begin
        if (st == S_READ)
          st <= S_DONE;
        else if (st != S_DONE)
          st <= S_CONF;
      end else if (rd_go) begin
        rd_vld <= 1'b1;
        case (st)
          S_RECV: begin
            rd_byte <= be_rdata;
            st <= S_DONE;
          end
          S_READ: begin
            rd_byte <= be_rdata;
            cnt <= cnt + CW'(1);
          end
          default: begin
            rd_byte <= '0;
            st <= S_CONF;
          end
        endcase
      end else if (wr_go) begin
        if (cnt == CW'(MAX_BYTES))
          overflow <= 1'b1;
        else begin
          cnt <= cnt + CW'(1);
          if (cnt == '0)
            cmd <= wr_byte;
          else begin
            write_stb <= 1'b1;
            write_off <= cnt - CW'(1);
            write_data <= wr_byte;
          end
        end
      end
    end
  end

  // R2
  quick_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quick_stb |-> $past(stop));

  // R5
  write_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    write_stb |-> ($past(wr_vld) && !overflow));

  // R6
  rd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |-> $past(rd_req));

  // R11
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!confused && !overflow));

  // R12
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !stop) |=> overflow);

  // R13
  one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({quick_stb, send_stb, write_stb, stop_err, rd_vld}));

endmodule

// File: tb/tb_smbus_target_decoder.sv
module tb_smbus_target_decoder;
  localparam int CW = 6;

  logic clk = 0, rst_n = 0;
  logic start_wr = 0, start_rd = 0, stop = 0, nack = 0, wr_vld = 0, rd_req = 0;
  logic [7:0] wr_byte = 0;
  logic [7:0] rd_byte, send_data, write_cmd, write_data, read_cmd, be_rdata;
  logic rd_vld, quick_stb, quick_rd, send_stb, write_stb, recv_req, read_req;
  logic confused, overflow, stop_err;
  logic [CW-1:0] write_off, read_off;

  int checks = 0, errors = 0;
  bit done = 0;
  logic cap_recv, cap_read;
  logic [7:0] cap_cmd;
  logic [CW-1:0] cap_off;

  always #10 clk = ~clk;

  assign be_rdata = recv_req ? 8'hA5 : read_req ? read_cmd + 8'(read_off) : 8'h00;

  smbus_target_decoder dut (.*);

  localparam logic [7:0] WR_VEC [0:5] = '{8'h3C, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ev(input int kind, input logic [7:0] b = 0);
    @(negedge clk);
    case (kind)
      0: start_wr = 1;
      1: start_rd = 1;
      2: stop = 1;
      3: nack = 1;
      4: begin wr_vld = 1; wr_byte = b; end
      default: rd_req = 1;
    endcase
    #1;
    cap_recv = recv_req; cap_read = read_req; cap_cmd = read_cmd; cap_off = read_off;
    @(negedge clk);
    {start_wr, start_rd, stop, nack, wr_vld, rd_req} = '0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk({quick_stb, send_stb, write_stb, rd_vld, confused, overflow, stop_err} == 0 && rd_byte == 0,
        "R1", {quick_stb, send_stb, write_stb, rd_vld, confused, overflow, stop_err}, 0);

    // R2
    ev(0); ev(2);
    chk(quick_stb && !quick_rd, "R2", {quick_stb, quick_rd}, 2'b10);
    // R3
    ev(1); ev(2);
    chk(quick_stb && quick_rd, "R3", {quick_stb, quick_rd}, 2'b11);
    // R4
    ev(0); ev(4, 8'h5A);
    chk(!write_stb, "R4", write_stb, 0);
    ev(2);
    chk(send_stb && send_data == 8'h5A, "R4", send_data, 8'h5A);

    // R5 table walk, then R7 read after multi-byte write
    ev(0);
    for (int i = 0; i < 6; i++) begin
      ev(4, WR_VEC[i]);
      if (i == 0) chk(!write_stb, "R5", write_stb, 0);
      else chk(write_stb && write_cmd == 8'h3C && write_off == CW'(i - 1) && write_data == WR_VEC[i],
               "R5", {write_off, write_data}, {CW'(i - 1), WR_VEC[i]});
    end
    ev(1);
    chk(!confused, "R7", confused, 0);
    for (int k = 0; k < 3; k++) begin
      ev(5);
      chk(cap_read && cap_cmd == 8'h3C && cap_off == CW'(k), "R7", {cap_read, cap_off}, {1'b1, CW'(k)});
      chk(rd_vld && rd_byte == 8'h3C + 8'(k), "R7", rd_byte, 8'h3C + 8'(k));
    end
    // R9
    ev(3); ev(3);
    chk(!confused, "R9", confused, 0);
    ev(2);
    chk(!stop_err && !quick_stb && !send_stb, "R9", {stop_err, quick_stb, send_stb}, 0);

    // R7 single command byte then read
    ev(0); ev(4, 8'h20);
    chk(!write_stb, "R7", write_stb, 0);
    ev(1); ev(5);
    chk(rd_byte == 8'h20 && cap_off == 0, "R7", rd_byte, 8'h20);
    ev(5);
    chk(rd_byte == 8'h21 && cap_off == 1, "R7", rd_byte, 8'h21);
    // R13
    ev(2);
    chk(stop_err && !confused, "R13", stop_err, 1);

    // R6
    ev(1); ev(5);
    chk(cap_recv && rd_vld && rd_byte == 8'hA5, "R6", rd_byte, 8'hA5);
    ev(4, 8'h77);
    chk(!write_stb, "R10", write_stb, 0);
    ev(5);
    chk(rd_vld && rd_byte == 0 && confused, "R6", {confused, rd_byte}, 9'h100);
    // R11
    ev(2);
    chk(!confused && !quick_stb, "R11", {confused, quick_stb}, 0);

    // R10 byte in receive state does not alter quick read
    ev(1); ev(4, 8'h66);
    chk(!write_stb, "R10", write_stb, 0);
    ev(2);
    chk(quick_stb && quick_rd && !send_stb, "R10", {quick_stb, quick_rd, send_stb}, 3'b110);

    // R8
    ev(0); ev(0);
    chk(confused, "R8", confused, 1);
    ev(1);
    chk(confused, "R11", confused, 1);
    ev(2);
    ev(0); ev(1);
    chk(confused, "R8", confused, 1);
    ev(2);
    chk(!confused && !quick_stb, "R11", {confused, quick_stb}, 0);

    // R9 NACK while idle
    ev(3);
    chk(confused, "R9", confused, 1);
    ev(2);

    // R12
    ev(0);
    for (int i = 0; i < 34; i++) ev(4, 8'(i));
    chk(write_stb && write_off == CW'(32) && write_data == 8'd33 && !overflow, "R12", write_off, 32);
    ev(4, 8'hEE);
    chk(!write_stb && overflow, "R12", {write_stb, overflow}, 2'b01);
    ev(4, 8'hEF);
    chk(overflow && !write_stb, "R12", overflow, 1);
    ev(2);
    chk(!overflow && !quick_stb && !send_stb, "R12", overflow, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule